// File: doc/BRIEF.md
# Fan PWM Duty Arbiter with Thermal Lock

This block drives one fan PWM output. Each cycle it picks the duty cycle to apply from several sources: a set of automatic duty requests from the fan control loops, an optional manual override held in a small 8-bit control register, a sticky thermal lock that forces full speed, and a spin-up interval that forces full speed after a start pulse. The applied duty is the largest of the active requests. A forcing source (lock or spin-up) overrides all others.

Software writes and reads the control register over a simple single-cycle register port. A read returns the 4-bit code of the duty currently applied, not the stored override value, so software sees what the fan is really getting. During spin-up that field reads zero. The PWM waveform has a period of 15 clock-enable ticks and can be inverted for fans whose drive is active low.

Top module: `fan_pwm_channel`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` reads 00h and `pwm_out` is low.
- R2: Register fields are: bits 7:4 override code, bit 3 lock flag, bit 2 lock enable, bit 1 invert, bit 0 override enable. A write with `wr_en` stores bits 7:4, 2, 1 and 0. Bits 2:0 read back as written from the next cycle on.
- R3: While override enable is 1, the stored code n requests a duty of n/15 of full scale (n*STEP on the DUTY_W-bit scale, STEP = (2^DUTY_W-1)/15). While it is 0, the stored code has no effect on the output or the readback.
- R4: One cycle after the inputs settle, the applied duty equals the maximum of all automatic requests and the override request. Bits 7:4 of `rd_data` report floor(applied/STEP).
- R5: The PWM counter steps 0..14 once per tick of TICK_DIV clocks. The non-inverted output is high while counter < code, so code 15 is constantly high and code 0 constantly low. `pwm_out` is registered one cycle after the counter and code.
- R6: With invert set, the output is the complement of the R5 waveform, so code 15 gives a constantly low output.
- R7: A `hot_evt` pulse sets the lock flag only if the stored lock enable is 1. With lock enable at 0, the flag stays 0.
- R8: While the lock flag is 1, the applied duty is full scale and bits 7:4 read Fh.
- R9: The lock flag clears only on a write with bit 3 equal to 0. Writing 1 to bit 3 leaves it unchanged. A `hot_evt` that sets the flag in the same cycle as a clearing write wins.
- R10: A `spin_start` pulse loads `spin_periods` into a spin-up counter. The counter decrements at each PWM period end. While it is non-zero, the duty is full scale and bits 7:4 read 0h. A load of 0 starts no spin-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback with live duty code |
| auto_duty | input | N_AUTO*DUTY_W | Packed automatic duty requests |
| hot_evt | input | 1 | Processor-hot event bound to this channel |
| spin_start | input | 1 | One-cycle spin-up start pulse |
| spin_periods | input | SPIN_W | Spin-up length in PWM periods |
| pwm_out | output | 1 | PWM drive output |

## Verification
The assertions assume that `hot_evt`, `spin_start` and `wr_en` are synchronous to `clk` and free of X after reset. They also assume that reset is held for at least two cycles, so the history they read always comes from defined state. The bench drives every input on the falling edge and keeps each event a single-cycle pulse. It holds reset for several cycles. It changes the automatic requests only between register writes, so each stimulus phase can be traced to one requirement while the reference model is compared every cycle.

// File: rtl/fan_pwm_pkg.sv
// Package: shared types and constants for the fan PWM channel.
// Assumes the register layout is fixed at 8 bits with a 4-bit duty code.
package fan_pwm_pkg;
    localparam int CODE_W       = 4;
    localparam int PERIOD_TICKS = 15;
    localparam logic [CODE_W-1:0] CODE_MAX = 4'hF;

    typedef struct packed {
        logic [CODE_W-1:0] ovr_code;
        logic              lock;
        logic              lock_en;
        logic              inv;
        logic              ovr_en;
    } ctrl_t;
endpackage

// File: rtl/fan_ctrl_reg.sv
// Module: control register with the sticky thermal lock flag.
// Assumes hot_evt and wr_en are synchronous single-cycle strobes.
// The lock flag is set only by hardware and cleared only by writing 0 to bit 3.
// A set and a clear in the same cycle resolve to set.
module fan_ctrl_reg
    import fan_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       hot_evt,
    output ctrl_t      ctrl
);
    ctrl_t wr_view;
    assign wr_view = ctrl_t'(wr_data);

    // Store writable fields and update the sticky lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_en) begin
                ctrl.ovr_code <= wr_view.ovr_code;
                ctrl.lock_en  <= wr_view.lock_en;
                ctrl.inv      <= wr_view.inv;
                ctrl.ovr_en   <= wr_view.ovr_en;
            end
            if (hot_evt && ctrl.lock_en)
                ctrl.lock <= 1'b1;
            else if (wr_en && !wr_view.lock)
                ctrl.lock <= 1'b0;
        end
    end

    AST_LOCK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.lock) |-> $past(ctrl.lock_en && hot_evt)) else $error("lock set without enable"); // R7
    AST_LOCK_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl.lock) |-> $past(wr_en && !wr_data[3])) else $error("lock cleared without write"); // R9
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_evt && ctrl.lock_en) |=> ctrl.lock) else $error("event lost to clear"); // R9
endmodule

// File: rtl/fan_duty_arb.sv
// Module: duty arbitration and spin-up interval.
// Picks the maximum of the automatic and override requests, forces full scale
// during lock or spin-up, and registers the applied duty and its 4-bit code.
// Assumes DUTY_W is a multiple of 4, so full scale divides evenly by 15.
module fan_duty_arb
    import fan_pwm_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int N_AUTO = 2,
    parameter int SPIN_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_AUTO*DUTY_W-1:0] auto_duty,
    input  logic                     ovr_en,
    input  logic [CODE_W-1:0]        ovr_code,
    input  logic                     lock,
    input  logic                     spin_start,
    input  logic [SPIN_W-1:0]        spin_periods,
    input  logic                     period_end,
    output logic [DUTY_W-1:0]        applied_q,
    output logic [CODE_W-1:0]        code,
    output logic                     spin_active
);
    localparam int N_REQ = N_AUTO + 1;
    localparam logic [DUTY_W-1:0] FULL = {DUTY_W{1'b1}};
    localparam logic [DUTY_W-1:0] STEP = DUTY_W'((2**DUTY_W - 1) / PERIOD_TICKS);

    logic [DUTY_W-1:0] req [N_REQ];
    logic [DUTY_W-1:0] req_max;
    logic [SPIN_W-1:0] spin_left;

    // Unpack the automatic requests into the request array.
    genvar gi;
    generate
        for (gi = 0; gi < N_AUTO; gi++) begin : g_auto
            assign req[gi] = auto_duty[gi*DUTY_W +: DUTY_W];
        end
    endgenerate

    // Override request: code scaled to the duty range, zero when disabled.
    assign req[N_AUTO] = ovr_en ? DUTY_W'(DUTY_W'(ovr_code) * STEP) : '0;

    // Maximum over all requesters.
    always_comb begin
        req_max = '0;
        for (int i = 0; i < N_REQ; i++)
            if (req[i] > req_max) req_max = req[i];
    end

    assign spin_active = (spin_left != '0);

    // Register the applied duty, with lock and spin-up forcing full scale.
    always_ff @(posedge clk) begin
        if (!rst_n)
            applied_q <= '0;
        else if (lock || spin_active)
            applied_q <= FULL;
        else
            applied_q <= req_max;
    end

    // Spin-up period counter: loaded by the start pulse, counts period ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            spin_left <= '0;
        else if (spin_start)
            spin_left <= spin_periods;
        else if (period_end && spin_active)
            spin_left <= spin_left - 1'b1;
    end

    // Rounded-down code of the applied duty.
    assign code = CODE_W'(applied_q / STEP);

    AST_LOCK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> (applied_q == FULL)) else $error("lock not at full duty"); // R8
    AST_SPIN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        spin_active |=> (applied_q == FULL)) else $error("spin-up not at full duty"); // R10
    AST_MAX_COVERS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en |=> (applied_q >= $past(DUTY_W'(DUTY_W'(ovr_code) * STEP)))) else $error("override lost"); // R4
    AST_SPIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        spin_start |=> (spin_left == $past(spin_periods))) else $error("spin load wrong"); // R10
endmodule

// File: rtl/fan_pwm_gen.sv
// Module: PWM waveform generator.
// A prescaler makes a tick every TICK_DIV clocks. A 0..14 counter steps on
// each tick, and the output is high while counter < code, then optionally inverted.
// Assumes TICK_DIV >= 2.
module fan_pwm_gen
    import fan_pwm_pkg::*;
#(
    parameter int TICK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              inv_in,
    output logic              pwm_q,
    output logic              period_end
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [CODE_W-1:0] CNT_LAST = CODE_W'(PERIOD_TICKS - 1);

    logic [PRE_W-1:0]  pre;
    logic [CODE_W-1:0] cnt;
    logic              tick;

    assign tick       = (pre == PRE_LAST);
    assign period_end = tick && (cnt == CNT_LAST);

    // Prescaler producing the clock-enable tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     pre <= '0;
        else if (tick)  pre <= '0;
        else            pre <= pre + 1'b1;
    end

    // Period counter stepping 0..14 on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (period_end) cnt <= '0;
        else if (tick)       cnt <= cnt + 1'b1;
    end

    // Registered compare and optional inversion.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= (cnt < code_in) ^ inv_in;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST) else $error("counter out of range"); // R5
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(code_in == CODE_MAX && !inv_in) |-> pwm_q) else $error("full duty not high"); // R5
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(code_in == '0 && !inv_in) |-> !pwm_q) else $error("zero duty not low"); // R5
    AST_INV_FULL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(code_in == CODE_MAX && inv_in) |-> !pwm_q) else $error("inverted full not low"); // R6
endmodule

// File: rtl/fan_pwm_channel.sv
// Module: top of one fan PWM channel.
// Ties the control register, the duty arbiter and the PWM generator together
// and builds the readback word with the live duty code (zero during spin-up).
// Assumes a single-cycle register port with combinational readback.
module fan_pwm_channel
    import fan_pwm_pkg::*;
#(
    parameter int DUTY_W   = 8,
    parameter int N_AUTO   = 2,
    parameter int SPIN_W   = 4,
    parameter int TICK_DIV = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [7:0]               wr_data,
    output logic [7:0]               rd_data,
    input  logic [N_AUTO*DUTY_W-1:0] auto_duty,
    input  logic                     hot_evt,
    input  logic                     spin_start,
    input  logic [SPIN_W-1:0]        spin_periods,
    output logic                     pwm_out
);
    ctrl_t             ctrl;
    logic [DUTY_W-1:0] applied;
    logic [CODE_W-1:0] code;
    logic              spin_active;
    logic              period_end;

    fan_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .hot_evt (hot_evt),
        .ctrl    (ctrl)
    );

    fan_duty_arb #(.DUTY_W(DUTY_W), .N_AUTO(N_AUTO), .SPIN_W(SPIN_W)) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_duty    (auto_duty),
        .ovr_en       (ctrl.ovr_en),
        .ovr_code     (ctrl.ovr_code),
        .lock         (ctrl.lock),
        .spin_start   (spin_start),
        .spin_periods (spin_periods),
        .period_end   (period_end),
        .applied_q    (applied),
        .code         (code),
        .spin_active  (spin_active)
    );

    fan_pwm_gen #(.TICK_DIV(TICK_DIV)) u_pwm (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_in    (code),
        .inv_in     (ctrl.inv),
        .pwm_q      (pwm_out),
        .period_end (period_end)
    );

    // Readback word: live code, or zero while spin-up runs.
    always_comb begin
        rd_data      = ctrl;
        rd_data[7:4] = spin_active ? '0 : code;
    end

    AST_LOCK_READS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[3] && $past(rd_data[3]) && !spin_active) |-> (rd_data[7:4] == CODE_MAX))
        else $error("locked readback not full"); // R8
    AST_APPLIED_UNUSED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (rd_data[2:0] == $past(wr_data[2:0]))) else $error("field readback wrong"); // R2
endmodule

// File: tb/fan_pwm_channel_tb.sv
// Bench: behavioural reference model compared with the DUT on every cycle,
// plus directed checks at chosen points.
module fan_pwm_channel_tb;
    localparam int DUTY_W = 8, N_AUTO = 2, SPIN_W = 4, TICK_DIV = 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     wr_en = 1'b0;
    logic [7:0]               wr_data = '0;
    logic [7:0]               rd_data;
    logic [N_AUTO*DUTY_W-1:0] auto_duty = '0;
    logic                     hot_evt = 1'b0;
    logic                     spin_start = 1'b0;
    logic [SPIN_W-1:0]        spin_periods = '0;
    logic                     pwm_out;

    int errors = 0, checks = 0;
    string cur_req = "R1";
    bit done = 0;

    always #4 clk = ~clk;

    fan_pwm_channel #(.DUTY_W(DUTY_W), .N_AUTO(N_AUTO), .SPIN_W(SPIN_W), .TICK_DIV(TICK_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .auto_duty(auto_duty), .hot_evt(hot_evt), .spin_start(spin_start),
        .spin_periods(spin_periods), .pwm_out(pwm_out)
    );

    // Reference model state
    int m_code = 0, m_lock = 0, m_en = 0, m_inv = 0, m_oen = 0;
    int m_applied = 0, m_spin = 0, m_pre = 0, m_cnt = 0, m_pwm = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 0; m_lock = 0; m_en = 0; m_inv = 0; m_oen = 0;
            m_applied = 0; m_spin = 0; m_pre = 0; m_cnt = 0; m_pwm = 0;
        end else begin
            int tick, pend, best, a, nlock;
            tick = (m_pre == TICK_DIV - 1);
            pend = tick && (m_cnt == 14);
            m_pwm = ((m_cnt < m_applied / 17) ? 1 : 0) ^ m_inv;
            best = m_oen ? m_code * 17 : 0;
            for (int i = 0; i < N_AUTO; i++) begin
                a = auto_duty[i*DUTY_W +: DUTY_W];
                if (a > best) best = a;
            end
            nlock = m_lock;
            if (hot_evt && m_en) nlock = 1;
            else if (wr_en && !wr_data[3]) nlock = 0;
            m_applied = (m_spin != 0 || m_lock) ? 255 : best;
            m_lock = nlock;
            if (wr_en) begin
                m_code = wr_data[7:4]; m_en = wr_data[2]; m_inv = wr_data[1]; m_oen = wr_data[0];
            end
            if (spin_start) m_spin = spin_periods;
            else if (pend && m_spin != 0) m_spin = m_spin - 1;
            m_pre = tick ? 0 : m_pre + 1;
            if (tick) m_cnt = (m_cnt == 14) ? 0 : m_cnt + 1;
        end
    end

    function automatic int exp_rd();
        int c;
        c = (m_spin != 0) ? 0 : m_applied / 17;
        return (c << 4) | (m_lock << 3) | (m_en << 2) | (m_inv << 1) | m_oen;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({cur_req, " readback"}, int'(rd_data), exp_rd());
            check({cur_req, " pwm"}, int'(pwm_out), m_pwm);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_auto(input int a0, input int a1);
        auto_duty = {DUTY_W'(a1), DUTY_W'(a0)};
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        cur_req = "R1";
        check("R1 reset readback", int'(rd_data), 0);
        check("R1 reset pwm", int'(pwm_out), 0);
        cyc(5);

        cur_req = "R3";
        wr(8'h51);                 // code 5, override on
        cyc(2);
        check("R3 override code 5", int'(rd_data[7:4]), 5);
        cur_req = "R5";
        cyc(70);
        cur_req = "R2";
        wr(8'h57);                 // lock_en, inv, ovr_en
        cyc(1);
        check("R2 low bits", int'(rd_data[2:0]), 7);
        wr(8'h51);

        cur_req = "R4";
        set_auto(200, 100);
        wr(8'h31);                 // override code 3
        cyc(2);
        check("R4 max of requests floor", int'(rd_data[7:4]), 11);
        set_auto(40, 120);
        cyc(3);
        check("R4 second auto wins", int'(rd_data[7:4]), 7);
        cyc(40);

        cur_req = "R3";
        set_auto(0, 0);
        wr(8'hF0);                 // code 15, override off
        cyc(3);
        check("R3 override disabled ignored", int'(rd_data[7:4]), 0);
        check("R3 pwm stays low", int'(pwm_out), 0);
        cyc(32);

        cur_req = "R5";
        wr(8'hF1);
        cyc(35);
        check("R5 full code constant high", int'(pwm_out), 1);

        cur_req = "R6";
        wr(8'hF3);
        cyc(35);
        check("R6 inverted full low", int'(pwm_out), 0);
        wr(8'h03);
        cyc(35);
        check("R6 inverted zero high", int'(pwm_out), 1);
        wr(8'h51);
        cyc(35);

        cur_req = "R7";
        @(negedge clk); hot_evt = 1'b1; @(negedge clk); hot_evt = 1'b0;
        cyc(2);
        check("R7 no lock without enable", int'(rd_data[3]), 0);
        wr(8'h25);                 // code 2, lock_en, override
        @(negedge clk); hot_evt = 1'b1; @(negedge clk); hot_evt = 1'b0;
        cyc(1);
        check("R7 lock set", int'(rd_data[3]), 1);
        cur_req = "R8";
        cyc(2);
        check("R8 locked reads full", int'(rd_data[7:4]), 15);
        cyc(35);

        cur_req = "R9";
        wr(8'h2D);                 // write 1 to lock bit
        cyc(2);
        check("R9 writing one keeps lock", int'(rd_data[3]), 1);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h25; hot_evt = 1'b1;
        @(negedge clk); wr_en = 1'b0; hot_evt = 1'b0;
        check("R9 event beats clear", int'(rd_data[3]), 1);
        wr(8'h25);
        cyc(2);
        check("R9 clear by zero", int'(rd_data[3]), 0);
        check("R9 duty resumes", int'(rd_data[7:4]), 2);
        cyc(35);

        cur_req = "R10";
        spin_periods = 4'd2;
        @(negedge clk); spin_start = 1'b1; @(negedge clk); spin_start = 1'b0;
        check("R10 spin reads zero", int'(rd_data[7:4]), 0);
        cyc(3);
        check("R10 spin pwm high", int'(pwm_out), 1);
        cyc(70);
        check("R10 spin ended", int'(rd_data[7:4]), 2);
        spin_periods = 4'd0;
        @(negedge clk); spin_start = 1'b1; @(negedge clk); spin_start = 1'b0;
        check("R10 zero length no spin", int'(rd_data[7:4]), 2);
        cyc(20);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule